// File: doc/BRIEF.md
# CORDIC Quadrature Down-Mixer with Phase Accumulator

This block moves a real-valued sample stream to complex baseband. A phase accumulator advances by a programmable increment once for each accepted sample. The current phase is taken as the mixing angle θ for that sample. Each sample is then rotated by −θ in a CORDIC datapath. The datapath uses no sine table and no multipliers, and it yields an in-phase and a quadrature value for every input sample.

The two most significant phase bits pick a rotation by a multiple of 90 degrees, applied once up front. The micro-rotation stages then only need to cover the remaining angle, which lies in the range 0 to 90 degrees. The stages are fully pipelined, so the block takes one sample per clock. The tuning word is written at run time over a one-cycle write port and does not disturb the running phase. At a 125 MHz sample clock, a 32-bit increment tunes from 0 Hz up to the Nyquist edge at 62.5 MHz, which covers the required 0 to 50 MHz. The CORDIC gain is not corrected, and the outputs have guard bits that absorb it.

Top module: `iq_cordic_mixer`

## Requirements
- R1: While rst_ni is low, iq_valid_o is 0. Reset clears both the phase and the increment to 0, so the first sample after reset is mixed at angle 0.
- R2: iq_valid_o is high after exactly NSTG+1 rising edges, counted from and including the edge that accepts a sample with smp_valid_i high (17 edges at the defaults). It is never high for any other cycle, including cycles with smp_valid_i low.
- R3: For a sample x (signed, DW bits) mixed at phase word P, θ = 2π·P/2^PW. The outputs are i_o ≈ G·x·cos θ and q_o ≈ −G·x·sin θ, both signed OW = DW+2 bits, within ±4 LSB. G is the uncompensated gain ∏ sqrt(1+2^(−2k)) for k = 0 … NSTG−1, about 1.6468.
- R4: The n-th accepted sample uses the sum of the increments applied at the previous accepted samples, taken modulo 2^PW. The phase does not move on cycles with smp_valid_i low.
- R5: A write with cfg_we_i high loads cfg_inc_i. The new increment is first added at the first sample accepted on a later edge. A sample accepted on the write edge itself still adds the old increment. The write leaves the accumulated phase untouched.
- R6: The phase bits [PW-1:PW-2] select the quadrant, and every quadrant is handled. With an increment of 2^(PW−2) (90° per sample), the outputs for consecutive samples step through (Gx, 0), (0, −Gx), (−Gx, 0), (0, Gx).
- R7: Full-scale inputs −2^(DW−1) and 2^(DW−1)−1, at any phase, give outputs whose magnitude stays below 2^DW, so the outputs never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_data_i | input | DW | Real input sample, two's complement |
| cfg_we_i | input | 1 | Increment write strobe |
| cfg_inc_i | input | PW | New phase increment per sample |
| iq_valid_o | output | 1 | Output strobe |
| i_o | output | DW+2 | In-phase result |
| q_o | output | DW+2 | Quadrature result |

## Verification
Each accepted sample's I/Q pair is due after the edge that lies NSTG edges later than its accepting edge. The bench therefore files the expected pair in a ring slot that many edges ahead, at the moment it drives the sample. After every edge it compares iq_valid_o and the data with the slot for that edge, so an early, late or extra strobe shows up in the cycle where it happens. The reference phase is advanced when the sample is driven, using the increment held before any write in the same cycle. This makes the one-sample delay of an increment change part of the check.

// File: rtl/iq_mix_pkg.sv
package iq_mix_pkg;
  // arctan(2^-k) in units of 2^32 per full turn, rescaled to pw bits
  function automatic logic [31:0] atan_step(input int unsigned k, input int unsigned pw);
    logic [31:0] a;
    case (k)
      0:  a = 32'd536870912;
      1:  a = 32'd316933406;
      2:  a = 32'd167458907;
      3:  a = 32'd85004756;
      4:  a = 32'd42667331;
      5:  a = 32'd21354465;
      6:  a = 32'd10679838;
      7:  a = 32'd5340245;
      8:  a = 32'd2670163;
      9:  a = 32'd1335087;
      10: a = 32'd667544;
      11: a = 32'd333772;
      12: a = 32'd166886;
      13: a = 32'd83443;
      14: a = 32'd41722;
      15: a = 32'd20861;
      default: a = 32'(64'd683565276 >> k);
    endcase
    return a >> (32 - pw);
  endfunction
endpackage

// File: rtl/iq_mix_nco.sv
module iq_mix_nco #(
  parameter int PW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          we_i,
  input  logic [PW-1:0] inc_i,
  output logic [PW-1:0] phase_o,
  output logic [PW-1:0] inc_o
);
  logic [PW-1:0] ph_q, inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      inc_q <= '0;
    end else begin
      if (adv_i) ph_q <= ph_q + inc_q;  // old increment on a write edge
      if (we_i)  inc_q <= inc_i;
    end
  end

  assign phase_o = ph_q;
  assign inc_o   = inc_q;
endmodule

// File: rtl/iq_mix_prerot.sv
module iq_mix_prerot #(
  parameter int DW   = 14,
  parameter int FRAC = 4,
  parameter int IW   = 20,
  parameter int PW   = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] data_i,
  input  logic        [PW-1:0] phase_i,
  output logic                 valid_o,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [PW-1:0] z_o
);
  logic signed [IW-1:0] xs, x_d, y_d;
  logic signed [PW-1:0] z_d;

  assign xs  = IW'(data_i) <<< FRAC;
  // residual angle in [0,90deg), rotated by its negative
  assign z_d = -$signed({2'b00, phase_i[PW-3:0]});

  // rotate (xs,0) by -q*90deg
  always_comb begin
    case (phase_i[PW-1:PW-2])
      2'd0:    begin x_d = xs;  y_d = '0;  end
      2'd1:    begin x_d = '0;  y_d = -xs; end
      2'd2:    begin x_d = -xs; y_d = '0;  end
      default: begin x_d = '0;  y_d = xs;  end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      z_o     <= '0;
    end else begin
      valid_o <= valid_i;
      x_o     <= x_d;
      y_o     <= y_d;
      z_o     <= z_d;
    end
  end
endmodule

// File: rtl/iq_mix_stage.sv
module iq_mix_stage #(
  parameter int IW  = 20,
  parameter int PW  = 32,
  parameter int IDX = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic signed [PW-1:0] z_i,
  output logic                 valid_o,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [PW-1:0] z_o
);
  import iq_mix_pkg::*;
  localparam logic signed [PW-1:0] ANG = PW'(atan_step(IDX, PW));

  logic signed [IW-1:0] xsh, ysh;
  assign xsh = x_i >>> IDX;
  assign ysh = y_i >>> IDX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      z_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (z_i[PW-1]) begin
        x_o <= x_i + ysh;
        y_o <= y_i - xsh;
        z_o <= z_i + ANG;
      end else begin
        x_o <= x_i - ysh;
        y_o <= y_i + xsh;
        z_o <= z_i - ANG;
      end
    end
  end
endmodule

// File: rtl/iq_cordic_mixer.sv
module iq_cordic_mixer #(
  parameter int DW    = 14,
  parameter int PW    = 32,
  parameter int NSTG  = 16,
  parameter int GUARD = 2,
  parameter int FRAC  = 4,
  localparam int OW   = DW + GUARD,
  localparam int IW   = OW + FRAC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_data_i,
  input  logic          cfg_we_i,
  input  logic [PW-1:0] cfg_inc_i,
  output logic          iq_valid_o,
  output logic [OW-1:0] i_o,
  output logic [OW-1:0] q_o
);
  logic [PW-1:0] phase_w, inc_w;

  logic                 v_s [NSTG+1];
  logic signed [IW-1:0] x_s [NSTG+1];
  logic signed [IW-1:0] y_s [NSTG+1];
  logic signed [PW-1:0] z_s [NSTG+1];

  iq_mix_nco #(.PW(PW)) u_nco (
    .clk_i, .rst_ni,
    .adv_i(smp_valid_i), .we_i(cfg_we_i), .inc_i(cfg_inc_i),
    .phase_o(phase_w), .inc_o(inc_w)
  );

  iq_mix_prerot #(.DW(DW), .FRAC(FRAC), .IW(IW), .PW(PW)) u_pre (
    .clk_i, .rst_ni,
    .valid_i(smp_valid_i), .data_i($signed(smp_data_i)), .phase_i(phase_w),
    .valid_o(v_s[0]), .x_o(x_s[0]), .y_o(y_s[0]), .z_o(z_s[0])
  );

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    iq_mix_stage #(.IW(IW), .PW(PW), .IDX(g)) u_stg (
      .clk_i, .rst_ni,
      .valid_i(v_s[g]), .x_i(x_s[g]), .y_i(y_s[g]), .z_i(z_s[g]),
      .valid_o(v_s[g+1]), .x_o(x_s[g+1]), .y_o(y_s[g+1]), .z_o(z_s[g+1])
    );
  end

  assign iq_valid_o = v_s[NSTG];
  assign i_o        = x_s[NSTG][IW-1:FRAC];
  assign q_o        = y_s[NSTG][IW-1:FRAC];
endmodule

// File: rtl/iq_mix_chk.sv
module iq_mix_chk #(
  parameter int DW   = 14,
  parameter int OW   = 16,
  parameter int PW   = 32,
  parameter int NSTG = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          smp_valid_i,
  input logic          cfg_we_i,
  input logic [PW-1:0] cfg_inc_i,
  input logic          iq_valid_o,
  input logic [OW-1:0] i_o,
  input logic [OW-1:0] q_o,
  input logic [PW-1:0] phase_i,
  input logic [PW-1:0] inc_i
);
  int unsigned fly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fly_q <= 0;
    else fly_q <= fly_q + 32'(smp_valid_i) - 32'(iq_valid_o);
  end

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni) iq_valid_o |-> fly_q != 0); // R2
  AST_FLIGHT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni) fly_q <= NSTG + 1); // R2
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !smp_valid_i |=> $stable(phase_i)); // R4
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni) smp_valid_i |=> phase_i == $past(phase_i + inc_i)); // R4
  AST_INC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni) cfg_we_i |=> inc_i == $past(cfg_inc_i)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iq_valid_o |-> ($signed(i_o) < $signed(OW'(1 << DW)) && $signed(i_o) > -$signed(OW'(1 << DW))
                 && $signed(q_o) < $signed(OW'(1 << DW)) && $signed(q_o) > -$signed(OW'(1 << DW)))); // R7
endmodule

bind iq_cordic_mixer iq_mix_chk #(.DW(DW), .OW(OW), .PW(PW), .NSTG(NSTG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i),
  .cfg_we_i(cfg_we_i), .cfg_inc_i(cfg_inc_i),
  .iq_valid_o(iq_valid_o), .i_o(i_o), .q_o(q_o),
  .phase_i(phase_w), .inc_i(inc_w)
);

// File: tb/sim_iq_cordic_mixer.sv
`timescale 1ns/1ps
module sim_iq_cordic_mixer;
  localparam int DW = 14, PW = 32, NSTG = 16, OW = DW + 2;
  localparam int RING = 64;
  localparam real TOL = 4.0;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, cfg_we = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [PW-1:0] cfg_inc = '0;
  logic iq_valid;
  logic [OW-1:0] i_out, q_out;

  int n_run = 0, n_fail = 0;
  real gain;
  longint unsigned ph_m = 0, inc_m = 0;
  int edge_idx = 0;
  bit  exp_v [RING];
  int  exp_x [RING];
  longint unsigned exp_p [RING];
  string exp_tag [RING];

  always #2.5 clk = ~clk;

  iq_cordic_mixer u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .cfg_we_i(cfg_we), .cfg_inc_i(cfg_inc), .iq_valid_o(iq_valid), .i_o(i_out), .q_o(q_out)
  );

  task automatic fail_line(string tag, string what, real act, real exp);
    n_fail++;
    $display("FAIL %s %s: actual %0.2f expected %0.2f", tag, what, act, exp);
  endtask

  // drive one cycle at negedge, then check the outputs due after the next edge
  task automatic cycle(bit v, int x, bit we, longint unsigned inc, string tag);
    int s;
    real th, ei, eq, ai, aq;
    smp_valid = v; smp_data = DW'(x); cfg_we = we; cfg_inc = PW'(inc);
    if (v) begin
      s = (edge_idx + NSTG) % RING;
      exp_v[s] = 1'b1; exp_x[s] = x; exp_p[s] = ph_m; exp_tag[s] = tag;
      ph_m = (ph_m + inc_m) & 64'hFFFF_FFFF;  // R4: old increment on write edge (R5)
    end
    if (we) inc_m = inc;
    @(posedge clk);
    @(negedge clk);
    s = edge_idx % RING;
    n_run++;
    if (iq_valid !== exp_v[s]) fail_line("R2", "iq_valid_o", real'(iq_valid), real'(exp_v[s]));
    else if (exp_v[s]) begin
      th = 2.0 * PI * real'(exp_p[s]) / 4294967296.0;
      ei = gain * real'(exp_x[s]) * $cos(th);
      eq = -gain * real'(exp_x[s]) * $sin(th);
      ai = real'($signed(i_out)); aq = real'($signed(q_out));
      n_run++;
      if ((ai - ei > TOL) || (ei - ai > TOL) || (aq - eq > TOL) || (eq - aq > TOL)) begin
        fail_line(exp_tag[s], "i_o", ai, ei);
        $display("FAIL %s q_o: actual %0.2f expected %0.2f", exp_tag[s], aq, eq);
      end
    end
    exp_v[s] = 1'b0;
    edge_idx++;
    smp_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic flush();
    for (int k = 0; k < NSTG + 2; k++) cycle(1'b0, 0, 1'b0, 0, "R2");
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    gain = 1.0;
    for (int k = 0; k < NSTG; k++) gain = gain * $sqrt(1.0 + 2.0 ** (-2.0 * k));
    for (int k = 0; k < RING; k++) exp_v[k] = 1'b0;
    seed_dummy = $urandom(32'd4242);

    // R1: quiet during reset
    repeat (3) @(negedge clk);
    n_run++;
    if (iq_valid !== 1'b0) fail_line("R1", "iq_valid_o in reset", real'(iq_valid), 0.0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: zero phase, zero increment after reset
    cycle(1'b1, 3000, 1'b0, 0, "R1");
    cycle(1'b1, -2500, 1'b0, 0, "R1");
    flush();

    // R6: 90 degrees per sample through all quadrants
    cycle(1'b0, 0, 1'b1, 64'h4000_0000, "R6");
    for (int k = 0; k < 8; k++) cycle(1'b1, 5000, 1'b0, 0, "R6");
    flush();

    // R5: write on a sample edge, then later samples use new step
    cycle(1'b1, 4000, 1'b1, 64'h0123_4567, "R5");
    cycle(1'b1, 4000, 1'b0, 0, "R5");
    cycle(1'b1, 4000, 1'b1, 64'hF000_0001, "R5");
    cycle(1'b1, -4000, 1'b0, 0, "R5");
    cycle(1'b1, 4000, 1'b0, 0, "R5");
    flush();

    // R4: gaps do not advance phase
    cycle(1'b0, 0, 1'b1, 64'h1555_5555, "R4");
    for (int k = 0; k < 10; k++) begin
      cycle(1'b1, 6000, 1'b0, 0, "R4");
      cycle(1'b0, 7777, 1'b0, 0, "R4");
      cycle(1'b0, -7777, 1'b0, 0, "R4");
    end
    flush();

    // R7: full scale at octant angles
    cycle(1'b0, 0, 1'b1, 64'h2000_0000, "R7");
    for (int k = 0; k < 16; k++)
      cycle(1'b1, (k % 2 == 0) ? -(1 << (DW - 1)) : (1 << (DW - 1)) - 1, 1'b0, 0, "R7");
    flush();

    // R3: random samples, gaps and increment writes
    for (int k = 0; k < 3000; k++) begin
      bit v, w;
      int x;
      v = ($urandom % 4) != 0;
      w = ($urandom % 50) == 0;
      x = int'($urandom % (1 << DW)) - (1 << (DW - 1));
      cycle(v, x, w, longint'($urandom), "R3");
    end
    flush();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule